// File: doc/BRIEF.md
# Colour Matrix and Key Scaler with Windowed Outputs

This block converts one pixel of three colour components and one key value per clock into three new colour components and a scaled key. Each colour output is a weighted sum of all three colour inputs (a 3x3 matrix). The key output is the key input times a single factor. Samples and coefficients are 13-bit two's complement. A coefficient is a fraction in the range [-1, 1), with its least significant bit worth 2^-12.

Each lane forms a full-precision result and keeps its 20 most significant bits. A per-lane two-bit window code picks which 13 of those bits leave the block. The result is rounded to nearest (half rounds upward) and clamped to the 13-bit range. The colour lanes and the key lane hold their binary points in different places, so the same window code gives them different gains.

Coefficients and window codes live in several register sets, written through a simple write port. A select input chooses the set for each sample. That choice travels down the pipeline with the sample.

Top module: `cmx_top`

## Requirements
- R1: With colour input vector (a0,a1,a2), raw coefficients c[r][j] and S = sum over j of c[r][j]*aj, colour output r equals clamp(floor((S + 2^(11+w)) / 2^(12+w))), where w is that lane's window code (0..3).
- R2: With raw key coefficient k and key input d, the key output equals clamp(floor((k*d + 2^(9+w)) / 2^(10+w))), where w is the key lane's window code. At w=0 the key lane therefore has a gain of 4 relative to the colour lanes.
- R3: Results above 4095 leave as 4095 and results below -4096 leave as -4096.
- R4: There are NSETS register sets, written when `wr_en` is high to the set given by `wr_set`. The address map is:
  - addresses 0..8 hold c[r][j] at address r*3+j;
  - address 9 holds the key coefficient;
  - address 10 holds the window codes: bits [1:0] colour lane 0, [3:2] lane 1, [5:4] lane 2, [7:6] key lane.
  Writes to a set that is not selected do not change the outputs.
- R5: `set_sel` is sampled together with the sample while `in_valid` is high. Back-to-back samples that use different sets each get their own set in full, both coefficients and window codes.
- R6: A sample presented with `in_valid` high at one rising edge appears, with `out_valid` high, three rising edges later. `out_valid` is low for a slot without input.
- R7: After reset all outputs are 0 and `out_valid` is low. Every coefficient and window code is 0, so a sample sent before any write produces all-zero results.
- R8: Writes to addresses 11..15 change no stored value.
- R9: A register write takes effect for a sample presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | SELW | Register set being written |
| wr_addr | input | 4 | Register address within the set |
| wr_data | input | W | Write data |
| set_sel | input | SELW | Register set applied to the sample at the inputs |
| in_valid | input | 1 | A sample is present at the inputs |
| in_c0 | input | W | Colour input 0 |
| in_c1 | input | W | Colour input 1 |
| in_c2 | input | W | Colour input 2 |
| in_key | input | W | Key input |
| out_valid | output | 1 | Outputs carry a result |
| out_c0 | output | W | Colour output 0 |
| out_c1 | output | W | Colour output 1 |
| out_c2 | output | W | Colour output 2 |
| out_key | output | W | Key output |

## Verification
The bench builds the block with its default values, W=13 and NSETS=4.

A 13-bit width puts both extreme inputs (-4096 and 4095) within reach of the stimulus table. Full-scale products then overflow both clamp limits in the colour lanes and the key lane.

Four sets let one set stay at unit-style window codes while another uses codes 1, 2 and 3. A third set can be written while a different one is selected, and a fourth is never written, so it keeps its reset values.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
    localparam int CMX_AW       = 4;   // register address width
    localparam int CMX_NCOEF    = 10;  // 9 matrix entries + key factor
    localparam int CMX_ADDR_KEY = 9;
    localparam int CMX_ADDR_WIN = 10;
    localparam int CMX_NLANE    = 4;   // three colour lanes + key lane
    localparam int CMX_WINW     = 2;   // window code width
    localparam int CMX_FW       = 20;  // kept most significant bits

    typedef logic [CMX_WINW-1:0] win_code_t;
endpackage

// File: rtl/cmx_regbank.sv
module cmx_regbank
    import cmx_pkg::*;
#(
    parameter int W     = 13,
    parameter int NSETS = 4,
    localparam int SELW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SELW-1:0]     wr_set,
    input  logic [CMX_AW-1:0]   wr_addr,
    input  logic [W-1:0]        wr_data,
    input  logic [SELW-1:0]     rd_set,
    output logic signed [W-1:0] rd_coef [CMX_NCOEF],
    output win_code_t           rd_win  [CMX_NLANE]
);
    localparam logic [CMX_AW-1:0] A_NCOEF = CMX_AW'(CMX_NCOEF);
    localparam logic [CMX_AW-1:0] A_KEY   = CMX_AW'(CMX_ADDR_KEY);
    localparam logic [CMX_AW-1:0] A_WIN   = CMX_AW'(CMX_ADDR_WIN);

    logic signed [W-1:0] coef_q [NSETS][CMX_NCOEF];
    win_code_t           win_q  [NSETS][CMX_NLANE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int i = 0; i < CMX_NCOEF; i++) coef_q[s][i] <= '0;
                for (int l = 0; l < CMX_NLANE; l++) win_q[s][l] <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr < A_NCOEF) begin
                coef_q[wr_set][wr_addr] <= wr_data;
            end else if (wr_addr == A_WIN) begin
                for (int l = 0; l < CMX_NLANE; l++)
                    win_q[wr_set][l] <= wr_data[CMX_WINW*l +: CMX_WINW];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < CMX_NCOEF; i++) rd_coef[i] = coef_q[rd_set][i];
        for (int l = 0; l < CMX_NLANE; l++) rd_win[l] = win_q[rd_set][l];
    end

    AST_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_KEY) |=> coef_q[$past(wr_set)][CMX_ADDR_KEY] == $past(wr_data)); // R4
endmodule

// File: rtl/cmx_mac.sv
module cmx_mac
    import cmx_pkg::*;
#(
    parameter int W      = 13,
    parameter int NTERMS = 3,
    parameter int GUARD  = 2,
    parameter int FW     = CMX_FW,
    localparam int PW    = 2 * W,
    localparam int SW    = PW + GUARD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [W-1:0]  i_data [NTERMS],
    input  logic signed [W-1:0]  i_coef [NTERMS],
    output logic signed [FW-1:0] o_word
);
    logic signed [PW-1:0] prod_q [NTERMS];
    logic signed [SW-1:0] sum_d;
    logic signed [SW-1:0] sum_q;

    // stage 1: products
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NTERMS; t++) prod_q[t] <= '0;
        end else begin
            for (int t = 0; t < NTERMS; t++) prod_q[t] <= i_data[t] * i_coef[t];
        end
    end

    always_comb begin
        sum_d = '0;
        for (int t = 0; t < NTERMS; t++) sum_d = sum_d + SW'(prod_q[t]);
    end

    // stage 2: accumulated word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign o_word = sum_q[SW-1 -: FW];
endmodule

// File: rtl/cmx_window.sv
module cmx_window
    import cmx_pkg::*;
#(
    parameter int W  = 13,
    parameter int FW = CMX_FW,
    localparam int XW = FW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_valid,
    input  logic signed [FW-1:0] i_word,
    input  win_code_t            i_win,
    output logic signed [W-1:0]  o_data
);
    localparam logic signed [XW-1:0] MAXV = XW'((2 ** (W - 1)) - 1);
    localparam logic signed [XW-1:0] MINV = XW'(-(2 ** (W - 1)));

    logic signed [XW-1:0] half;
    logic signed [XW-1:0] biased;
    logic signed [XW-1:0] scaled;
    logic signed [W-1:0]  nxt;

    always_comb begin
        half = '0;
        half[3 + int'(i_win)] = 1'b1;
        biased = XW'(i_word) + half;
        scaled = biased >>> (4 + int'(i_win));
        if (scaled > MAXV)      nxt = MAXV[W-1:0];
        else if (scaled < MINV) nxt = MINV[W-1:0];
        else                    nxt = scaled[W-1:0];
    end

    // stage 3: rounded, clamped result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       o_data <= '0;
        else if (i_valid) o_data <= nxt;
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && scaled > MAXV) |=> o_data == MAXV[W-1:0]); // R3
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && scaled < MINV) |=> o_data == MINV[W-1:0]); // R3
endmodule

// File: rtl/cmx_top.sv
module cmx_top
    import cmx_pkg::*;
#(
    parameter int W     = 13,
    parameter int NSETS = 4,
    localparam int SELW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SELW-1:0]     wr_set,
    input  logic [CMX_AW-1:0]   wr_addr,
    input  logic [W-1:0]        wr_data,
    input  logic [SELW-1:0]     set_sel,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_c0,
    input  logic signed [W-1:0] in_c1,
    input  logic signed [W-1:0] in_c2,
    input  logic signed [W-1:0] in_key,
    output logic                out_valid,
    output logic signed [W-1:0] out_c0,
    output logic signed [W-1:0] out_c1,
    output logic signed [W-1:0] out_c2,
    output logic signed [W-1:0] out_key
);
    localparam int NMAT = 3;

    logic signed [W-1:0] rd_coef [CMX_NCOEF];
    win_code_t           rd_win  [CMX_NLANE];
    win_code_t           win_s1  [CMX_NLANE];
    win_code_t           win_s2  [CMX_NLANE];
    logic                v1, v2, v3;

    logic signed [W-1:0]      mat_in   [NMAT];
    logic signed [W-1:0]      mat_coef [NMAT][NMAT];
    logic signed [W-1:0]      key_in   [1];
    logic signed [W-1:0]      key_coef [1];
    logic signed [CMX_FW-1:0] word     [CMX_NLANE];
    logic signed [W-1:0]      res      [CMX_NLANE];

    cmx_regbank #(.W(W), .NSETS(NSETS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_set(set_sel),
        .rd_coef(rd_coef), .rd_win(rd_win)
    );

    always_comb begin
        mat_in[0] = in_c0;
        mat_in[1] = in_c1;
        mat_in[2] = in_c2;
        for (int r = 0; r < NMAT; r++)
            for (int j = 0; j < NMAT; j++)
                mat_coef[r][j] = rd_coef[r * NMAT + j];
        key_in[0]   = in_key;
        key_coef[0] = rd_coef[CMX_ADDR_KEY];
    end

    // window codes and valid travel with the sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
            for (int l = 0; l < CMX_NLANE; l++) begin
                win_s1[l] <= '0;
                win_s2[l] <= '0;
            end
        end else begin
            v1 <= in_valid; v2 <= v1; v3 <= v2;
            for (int l = 0; l < CMX_NLANE; l++) begin
                win_s1[l] <= rd_win[l];
                win_s2[l] <= win_s1[l];
            end
        end
    end

    for (genvar r = 0; r < NMAT; r++) begin : g_mat
        cmx_mac #(.W(W), .NTERMS(NMAT), .GUARD(2)) mac_i (
            .clk(clk), .rst_n(rst_n), .i_data(mat_in), .i_coef(mat_coef[r]),
            .o_word(word[r])
        );
    end

    cmx_mac #(.W(W), .NTERMS(1), .GUARD(0)) key_mac_i (
        .clk(clk), .rst_n(rst_n), .i_data(key_in), .i_coef(key_coef),
        .o_word(word[NMAT])
    );

    for (genvar l = 0; l < CMX_NLANE; l++) begin : g_win
        cmx_window #(.W(W)) win_i (
            .clk(clk), .rst_n(rst_n), .i_valid(v2), .i_word(word[l]),
            .i_win(win_s2[l]), .o_data(res[l])
        );
    end

    assign out_valid = v3;
    assign out_c0    = res[0];
    assign out_c1    = res[1];
    assign out_c2    = res[2];
    assign out_key   = res[3];

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##2 !out_valid); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !v2 |=> $stable(out_key)); // R6
endmodule

// File: tb/cmx_top_tb_top.sv
`timescale 1ns/1ps
module cmx_top_tb_top;
    localparam int W = 13;
    localparam int NSETS = 4;
    localparam int SELW = 2;
    localparam int NV = 8;

    // stimulus table: set, c0, c1, c2, key
    localparam int T_SEL [NV] = '{0, 0, 0, 1, 1, 1, 0, 1};
    localparam int T_A   [NV] = '{100, -4096, 4095, -4096, -4096, 4095, 0, -1};
    localparam int T_B   [NV] = '{200, 4095, 4095, -4096, 1000, 4095, 0, 1};
    localparam int T_C   [NV] = '{300, -1, 4095, -4096, -3000, 4095, 0, -1};
    localparam int T_K   [NV] = '{50, -4096, 4095, 7, -4096, 4095, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [SELW-1:0] wr_set = '0;
    logic [3:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [SELW-1:0] set_sel = '0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_c0 = '0, in_c1 = '0, in_c2 = '0, in_key = '0;
    logic out_valid;
    logic signed [W-1:0] out_c0, out_c1, out_c2, out_key;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int sh_c [NSETS][9];
    int sh_k [NSETS];
    int sh_w [NSETS][4];

    always #10 clk = ~clk;

    cmx_top #(.W(W), .NSETS(NSETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set),
        .wr_addr(wr_addr), .wr_data(wr_data), .set_sel(set_sel),
        .in_valid(in_valid), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .in_key(in_key), .out_valid(out_valid), .out_c0(out_c0),
        .out_c1(out_c1), .out_c2(out_c2), .out_key(out_key)
    );

    task automatic chk(string req, int got, int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int rnd_clamp(longint s, int sh);
        longint q;
        q = (s + (longint'(1) <<< (sh - 1))) >>> sh;
        if (q > 4095) q = 4095;
        if (q < -4096) q = -4096;
        return int'(q);
    endfunction

    // R1 / R2 reference from the stated formulas
    function automatic int expect_lane(int s, int lane, int a, int b, int c, int k);
        longint acc;
        if (lane < 3) begin
            acc = longint'(sh_c[s][lane*3]) * a + longint'(sh_c[s][lane*3+1]) * b
                + longint'(sh_c[s][lane*3+2]) * c;
            return rnd_clamp(acc, 12 + sh_w[s][lane]);
        end
        acc = longint'(sh_k[s]) * k;
        return rnd_clamp(acc, 10 + sh_w[s][3]);
    endfunction

    // register write, shadow follows the R4 map (R8: 11..15 store nothing)
    task automatic wreg(int s, int a, int d);
        wr_set = SELW'(s); wr_addr = 4'(a); wr_data = W'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 9) sh_c[s][a] = d;
        else if (a == 9) sh_k[s] = d;
        else if (a == 10) for (int l = 0; l < 4; l++) sh_w[s][l] = (d >> (2*l)) & 3;
    endtask

    task automatic drive(int s, int a, int b, int c, int k);
        set_sel = SELW'(s); in_c0 = W'(a); in_c1 = W'(b); in_c2 = W'(c); in_key = W'(k);
        in_valid = 1'b1;
    endtask

    task automatic check_out(string req, int s, int a, int b, int c, int k);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " c0"}, int'(out_c0), expect_lane(s, 0, a, b, c, k));
        chk({req, " c1"}, int'(out_c1), expect_lane(s, 1, a, b, c, k));
        chk({req, " c2"}, int'(out_c2), expect_lane(s, 2, a, b, c, k));
        chk({req, " key"}, int'(out_key), expect_lane(s, 3, a, b, c, k));
    endtask

    task automatic run_vec(string req, int s, int a, int b, int c, int k);
        drive(s, a, b, c, k);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_out(req, s, a, b, c, k);
    endtask

    initial begin
        for (int s = 0; s < NSETS; s++) begin
            sh_k[s] = 0;
            for (int i = 0; i < 9; i++) sh_c[s][i] = 0;
            for (int l = 0; l < 4; l++) sh_w[s][l] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        chk("R7 valid", int'(out_valid), 0);
        chk("R7 c0", int'(out_c0), 0);
        chk("R7 key", int'(out_key), 0);
        run_vec("R7 zero coefs", 3, 1234, -999, 4000, -77);

        // program set 0 and set 1
        wreg(0, 0, 1024); wreg(0, 1, 2048); wreg(0, 2, 512);
        wreg(0, 3, -1024); wreg(0, 4, 3000); wreg(0, 5, -700);
        wreg(0, 6, 4095); wreg(0, 7, -4096); wreg(0, 8, 100);
        wreg(0, 9, 2048); wreg(0, 10, 0);
        for (int i = 0; i < 3; i++) wreg(1, i, -4096);
        for (int i = 3; i < 6; i++) wreg(1, i, 4095);
        wreg(1, 6, 1000); wreg(1, 7, -2000); wreg(1, 8, 300);
        wreg(1, 9, -3000);
        wreg(1, 10, 249); // windows 1,2,3,3

        // R1 R2 R3: table walk (includes clamp-high and clamp-low cases)
        for (int v = 0; v < NV; v++)
            run_vec("R1 R2 R3 table", T_SEL[v], T_A[v], T_B[v], T_C[v], T_K[v]);

        // R3 explicit corners
        run_vec("R3 clamp", 1, -4096, -4096, -4096, -4096);
        chk("R3 high c0", int'(out_c0), 4095);
        run_vec("R3 clamp low", 0, 4095, 4095, 4095, -4096);
        chk("R3 low key", int'(out_key), -4096);

        // R8: reserved addresses store nothing
        wreg(0, 12, 4095);
        wreg(0, 15, 4095);
        run_vec("R8 reserved", 0, 100, 200, 300, 50);

        // R4: write to an unselected set, then use it
        wreg(2, 0, 1000);
        run_vec("R4 other set", 0, 100, 200, 300, 50);
        run_vec("R4 set2", 2, 100, 200, 300, 50);
        chk("R4 set2 c0", int'(out_c0), 24);

        // R9: write then sample next cycle
        wr_set = 2'd0; wr_addr = 4'd0; wr_data = W'(-2048); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sh_c[0][0] = -2048;
        run_vec("R9 next cycle", 0, 100, 200, 300, 50);

        // R5 R6: back-to-back samples with different sets
        drive(0, 1000, -2000, 3000, 777);
        @(negedge clk);
        chk("R6 not yet (1)", int'(out_valid), 0);
        drive(1, 500, 600, -700, -800);
        @(negedge clk);
        in_valid = 1'b0; set_sel = 2'd3;
        chk("R6 not yet (2)", int'(out_valid), 0);
        @(negedge clk);
        check_out("R5 R6 first", 0, 1000, -2000, 3000, 777);
        @(negedge clk);
        check_out("R5 second", 1, 500, 600, -700, -800);
        @(negedge clk);
        chk("R6 idle slot", int'(out_valid), 0);
        chk("R6 hold key", int'(out_key), expect_lane(1, 3, 500, 600, -700, -800));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule